// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block governs the sleep states of a small 8-bit microcontroller. Software writes a two-bit mode field. Bit 0 requests a light sleep, called idle. Bit 1 requests a deep sleep, called power-down. The request takes effect when the core signals that the current instruction has finished.

The block drives three enables:
- a clock enable for the CPU core;
- a clock enable for the peripheral group (interrupt logic, timers, watchdog, serial port);
- a run enable for the oscillator.

In idle only the core is stopped, and any enabled interrupt resumes it in the next cycle. In power-down everything stops. Only a qualified reset, or an external interrupt pin that is armed for level detection, can bring the device back. After such a wake, the oscillator is given a fixed settling window before any clock is re-enabled.

A reset qualifier accepts the external reset pin only after it has stayed high long enough. The qualified reset and the watchdog reset are merged into one reset output for the rest of the chip. The current state is reported on a two-bit status port.

Top module: `lpm_clkctl`

## Requirements
- R1: Status codes are 00 run, 01 idle, 10 power-down and 11 waking. A write with `reg_wr` loads `reg_wdata` into `mode_bits`, where bit 0 is idle and bit 1 is power-down. In run, the state moves to idle or power-down at the first clock edge where `insn_done` is high and the newly written or stored mode bits request it. Without `insn_done` the state stays run.
- R2: When bit 1 and bit 0 are both 1, power-down is entered, not idle.
- R3: In idle, `cpu_clk_en` is 0 while `per_clk_en` and `osc_en` are 1.
- R4: In idle, `irq_pend` high at a clock edge returns the state to run at that edge and clears mode bit 0, with no settling delay.
- R5: In power-down, `cpu_clk_en`, `per_clk_en` and `osc_en` are all 0. `irq_pend` alone does not leave power-down.
- R6: Power-down is left at an edge only when, for at least one pin i, all of the following hold: `ext_int_pin[i]` is high (the active level), `ext_int_en[i]` is 1, `ext_int_lvl[i]` is 1 (level detection), and `glob_int_en` is 1.
- R7: After a power-down wake, the state is waking for exactly `STAB_CYCLES` cycles (default 1024), with `osc_en` at 1 and both clock enables at 0. It then becomes run with both mode bits cleared.
- R8: `wdt_rst` is ignored in power-down and in waking. In run and idle it raises `sys_rst`.
- R9: The external reset pin is qualified on the `RST_MIN`-th consecutive high sample (default 24). `sys_rst` goes high in that cycle. A shorter pulse changes nothing.
- R10: At an edge where `sys_rst` is high, both mode bits clear. The state becomes run if it was run or idle, and waking (restarting the settling window) if it was power-down or waking.
- R11: Asserting `por_n` low forces run with both mode bits cleared, regardless of the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_pin | input | 1 | Raw external reset pin, active high |
| wdt_rst | input | 1 | Watchdog reset request |
| reg_wr | input | 1 | Write strobe for the mode field |
| reg_wdata | input | 2 | Mode field write data (bit 1 power-down, bit 0 idle) |
| insn_done | input | 1 | Current instruction completes this cycle |
| irq_pend | input | 1 | Any enabled interrupt is requesting service |
| ext_int_pin | input | N_EXT | External interrupt pins, active high |
| ext_int_en | input | N_EXT | Per-pin interrupt enables |
| ext_int_lvl | input | N_EXT | Per-pin detection mode, 1 = level |
| glob_int_en | input | 1 | Global interrupt enable |
| cpu_clk_en | output | 1 | CPU core clock enable |
| per_clk_en | output | 1 | Peripheral group clock enable |
| osc_en | output | 1 | Oscillator run enable |
| sys_rst | output | 1 | Qualified reset for the chip |
| mode_bits | output | 2 | Current mode field |
| state_o | output | 2 | Current state code |

## Verification
Some properties are checked on every cycle:
- the enable pattern of each state;
- power-down taking priority over idle;
- the single-edge idle wake;
- power-down holding unless a fully qualified pin wake occurs;
- the watchdog being ignored while asleep;
- reset clearing the mode bits.

A counter-based assertion checks the settling window length, and another checks that no reset escapes the pin filter.

Other behaviour only the bench scenarios can show:
- that a 23-cycle reset pulse leaves the stored mode untouched;
- that each of the four wake conditions is individually necessary;
- that a reset during power-down lands in the waking state;
- that random mixes of writes, interrupts and reset pulses follow the model's sequence.

// File: rtl/lpm_clkctl.sv
module lpm_clkctl #(
  parameter int N_EXT       = 2,
  parameter int RST_MIN     = 24,
  parameter int STAB_CYCLES = 1024
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             ext_rst_pin,
  input  logic             wdt_rst,
  input  logic             reg_wr,
  input  logic [1:0]       reg_wdata,
  input  logic             insn_done,
  input  logic             irq_pend,
  input  logic [N_EXT-1:0] ext_int_pin,
  input  logic [N_EXT-1:0] ext_int_en,
  input  logic [N_EXT-1:0] ext_int_lvl,
  input  logic             glob_int_en,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             osc_en,
  output logic             sys_rst,
  output logic [1:0]       mode_bits,
  output logic [1:0]       state_o
);
  localparam int RCW = $clog2(RST_MIN + 1);
  localparam int SCW = $clog2(STAB_CYCLES + 1);
  localparam logic [1:0] S_RUN  = 2'd0;
  localparam logic [1:0] S_IDLE = 2'd1;
  localparam logic [1:0] S_PD   = 2'd2;
  localparam logic [1:0] S_WAKE = 2'd3;

  logic [1:0]     st, bits, nb;
  logic [RCW-1:0] rc;
  logic [SCW-1:0] sc;
  logic           ext_ok, wdt_ok, pd_wake;

  assign ext_ok  = ext_rst_pin && (rc >= RCW'(RST_MIN - 1));
  assign wdt_ok  = wdt_rst && !st[1];
  assign sys_rst = ext_ok || wdt_ok;
  assign pd_wake = glob_int_en && |(ext_int_pin & ext_int_en & ext_int_lvl);
  assign nb      = reg_wr ? reg_wdata : bits;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                rc <= '0;
    else if (!ext_rst_pin)     rc <= '0;
    else if (rc != RCW'(RST_MIN)) rc <= rc + 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st   <= S_RUN;
      bits <= 2'b00;
      sc   <= '0;
    end else if (sys_rst) begin
      st   <= st[1] ? S_WAKE : S_RUN;
      bits <= 2'b00;
      sc   <= '0;
    end else begin
      case (st)
        S_RUN: begin
          bits <= nb;
          if (insn_done && nb[1])      st <= S_PD;
          else if (insn_done && nb[0]) st <= S_IDLE;
        end
        S_IDLE: if (irq_pend) begin
          st      <= S_RUN;
          bits[0] <= 1'b0;
        end
        S_PD: if (pd_wake) begin
          st <= S_WAKE;
          sc <= '0;
        end
        default: begin
          if (sc == SCW'(STAB_CYCLES - 1)) begin
            st   <= S_RUN;
            bits <= 2'b00;
            sc   <= '0;
          end else begin
            sc <= sc + 1'b1;
          end
        end
      endcase
    end
  end

  assign cpu_clk_en = (st == S_RUN);
  assign per_clk_en = !st[1];
  assign osc_en     = (st != S_PD);
  assign mode_bits  = bits;
  assign state_o    = st;
endmodule

// File: rtl/lpm_clkctl_chk.sv
module lpm_clkctl_chk #(
  parameter int N_EXT       = 2,
  parameter int RST_MIN     = 24,
  parameter int STAB_CYCLES = 1024
) (
  input logic             clk,
  input logic             por_n,
  input logic             ext_rst_pin,
  input logic             wdt_rst,
  input logic             reg_wr,
  input logic [1:0]       reg_wdata,
  input logic             insn_done,
  input logic             irq_pend,
  input logic [N_EXT-1:0] ext_int_pin,
  input logic [N_EXT-1:0] ext_int_en,
  input logic [N_EXT-1:0] ext_int_lvl,
  input logic             glob_int_en,
  input logic             cpu_clk_en,
  input logic             per_clk_en,
  input logic             osc_en,
  input logic             sys_rst,
  input logic [1:0]       mode_bits,
  input logic [1:0]       state_o
);
  logic [31:0] wake_n, hi_n;
  logic        qual_wake;

  assign qual_wake = glob_int_en && |(ext_int_pin & ext_int_en & ext_int_lvl);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      wake_n <= '0;
      hi_n   <= '0;
    end else begin
      wake_n <= (state_o == 2'd3 && !sys_rst) ? wake_n + 1 : '0;
      hi_n   <= !ext_rst_pin ? '0 : (hi_n < 32'(RST_MIN) ? hi_n + 1 : hi_n);
    end
  end

  p_pd_priority_r2: assert property (@(posedge clk) disable iff (!por_n)
    (state_o == 2'd0 && !sys_rst && reg_wr && insn_done && reg_wdata[1]) |=> state_o == 2'd2);

  p_idle_clocks_r3: assert property (@(posedge clk) disable iff (!por_n)
    state_o == 2'd1 |-> (per_clk_en && osc_en && !cpu_clk_en));

  p_idle_wake_r4: assert property (@(posedge clk) disable iff (!por_n)
    (state_o == 2'd1 && irq_pend && !sys_rst) |=> (state_o == 2'd0 && !mode_bits[0]));

  p_pd_clocks_r5: assert property (@(posedge clk) disable iff (!por_n)
    state_o == 2'd2 |-> (!osc_en && !cpu_clk_en && !per_clk_en));

  p_pd_hold_r6: assert property (@(posedge clk) disable iff (!por_n)
    (state_o == 2'd2 && !sys_rst && !qual_wake) |=> state_o == 2'd2);

  p_wake_clocks_r7: assert property (@(posedge clk) disable iff (!por_n)
    state_o == 2'd3 |-> (osc_en && !cpu_clk_en && !per_clk_en));

  p_wake_len_r7: assert property (@(posedge clk) disable iff (!por_n)
    (state_o == 2'd0 && $past(state_o) == 2'd3 && !$past(sys_rst)) |-> wake_n == 32'(STAB_CYCLES));

  p_wdt_ignored_r8: assert property (@(posedge clk) disable iff (!por_n)
    (state_o[1] && !ext_rst_pin) |-> !sys_rst);

  p_rst_filter_r9: assert property (@(posedge clk) disable iff (!por_n)
    (sys_rst && !wdt_rst) |-> (ext_rst_pin && hi_n >= 32'(RST_MIN - 1)));

  p_rst_clears_r10: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst |=> mode_bits == 2'b00);
endmodule

bind lpm_clkctl lpm_clkctl_chk #(.N_EXT(N_EXT), .RST_MIN(RST_MIN), .STAB_CYCLES(STAB_CYCLES)) u_chk (.*);

// File: tb/sim_lpm_clkctl.sv
module sim_lpm_clkctl;
  localparam int NE = 2, RM = 24, SB = 64;

  logic clk = 0, por_n = 0, ext_rst_pin = 0, wdt_rst = 0, reg_wr = 0, insn_done = 0, irq_pend = 0, glob_int_en = 0;
  logic [1:0] reg_wdata = 0;
  logic [NE-1:0] ext_int_pin = 0, ext_int_en = 0, ext_int_lvl = 0;
  logic cpu_clk_en, per_clk_en, osc_en, sys_rst;
  logic [1:0] mode_bits, state_o;

  int n_chk = 0, n_bad = 0, cyc_n = 0;
  logic [1:0] m_st = 0, m_bits = 0;
  int m_rc = 0, m_sc = 0;

  always #2.5 clk = ~clk;

  lpm_clkctl #(.N_EXT(NE), .RST_MIN(RM), .STAB_CYCLES(SB)) u0 (.*);

  function automatic logic m_rst();
    return (ext_rst_pin && m_rc >= RM - 1) || (wdt_rst && m_st < 2);
  endfunction

  function automatic logic m_wake();
    return glob_int_en && |(ext_int_pin & ext_int_en & ext_int_lvl);
  endfunction

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_st <= 0; m_bits <= 0; m_sc <= 0; m_rc <= 0;
    end else begin
      logic [1:0] nb;
      nb = reg_wr ? reg_wdata : m_bits;
      m_rc <= !ext_rst_pin ? 0 : (m_rc < RM ? m_rc + 1 : m_rc);
      if (m_rst()) begin
        m_st <= m_st[1] ? 2'd3 : 2'd0; m_bits <= 0; m_sc <= 0;
      end else case (m_st)
        2'd0: begin
          m_bits <= nb;
          if (insn_done && nb[1]) m_st <= 2'd2;
          else if (insn_done && nb[0]) m_st <= 2'd1;
        end
        2'd1: if (irq_pend) begin m_st <= 0; m_bits <= {m_bits[1], 1'b0}; end
        2'd2: if (m_wake()) begin m_st <= 3; m_sc <= 0; end
        default: if (m_sc == SB - 1) begin m_st <= 0; m_bits <= 0; m_sc <= 0; end
                 else m_sc <= m_sc + 1;
      endcase
    end
  end

  task automatic chk(input string tag);
    logic [7:0] got, exp;
    got = {state_o, mode_bits, cpu_clk_en, per_clk_en, osc_en, sys_rst};
    exp = {m_st, m_bits, m_st == 0, m_st < 2, m_st != 2, m_rst()};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got st/bits/cpu/per/osc/rst=%b expected %b at t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic cyc(input string tag);
    @(negedge clk);
    chk(tag);
  endtask

  function automatic string st_tag();
    case (m_st)
      2'd1: return "R3";
      2'd2: return "R5";
      2'd3: return "R7";
      default: return "R1";
    endcase
  endfunction

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_n++;
    if (cyc_n > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      finish_run();
    end
  end

  task automatic enter_pd();
    reg_wr = 1; reg_wdata = 2'b10; insn_done = 1; cyc("R1");
    reg_wr = 0; insn_done = 0;
  endtask

  task automatic pin_wake();
    ext_int_pin = 2'b01; ext_int_en = 2'b01; ext_int_lvl = 2'b01; glob_int_en = 1;
    cyc("R6");
    ext_int_pin = 0; ext_int_en = 0; ext_int_lvl = 0; glob_int_en = 0;
    repeat (SB + 2) cyc("R7");
  endtask

  initial begin
    int pulse;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    chk("R11");
    por_n = 1;
    cyc("R11");
    // R1: write without completion, then completion
    reg_wr = 1; reg_wdata = 2'b01; cyc("R1");
    reg_wr = 0; cyc("R1");
    insn_done = 1; cyc("R1");
    insn_done = 0; cyc("R3"); cyc("R3");
    irq_pend = 1; cyc("R4");
    irq_pend = 0;
    // R2: both bits at once
    reg_wr = 1; reg_wdata = 2'b11; insn_done = 1; cyc("R2");
    reg_wr = 0; insn_done = 0; irq_pend = 1;
    repeat (3) cyc("R5");
    irq_pend = 0;
    // R6: each condition missing in turn
    ext_int_pin = 2'b01; ext_int_en = 2'b01; ext_int_lvl = 2'b00; glob_int_en = 1; cyc("R6");
    ext_int_lvl = 2'b01; glob_int_en = 0; cyc("R6");
    glob_int_en = 1; ext_int_en = 2'b10; cyc("R6");
    ext_int_en = 2'b01; ext_int_pin = 2'b00; cyc("R6");
    pin_wake();
    // R8: watchdog while asleep, then while running
    enter_pd();
    wdt_rst = 1; cyc("R8"); cyc("R8");
    wdt_rst = 0; cyc("R8");
    pin_wake();
    reg_wr = 1; reg_wdata = 2'b01; cyc("R1");
    reg_wr = 0; wdt_rst = 1; cyc("R8");
    wdt_rst = 0; cyc("R10");
    // R9: short pulse keeps mode bits, long pulse clears them
    reg_wr = 1; reg_wdata = 2'b01; cyc("R1");
    reg_wr = 0;
    ext_rst_pin = 1; repeat (RM - 1) cyc("R9");
    ext_rst_pin = 0; cyc("R9"); cyc("R9");
    ext_rst_pin = 1; repeat (RM + 4) cyc("R9");
    ext_rst_pin = 0; cyc("R10");
    // R10: reset during power-down lands in waking
    enter_pd();
    ext_rst_pin = 1; repeat (RM + 2) cyc("R10");
    ext_rst_pin = 0; repeat (SB + 2) cyc("R10");
    // R11: asynchronous power-on reset from idle
    reg_wr = 1; reg_wdata = 2'b01; insn_done = 1; cyc("R3");
    reg_wr = 0; insn_done = 0;
    #1 por_n = 0; #1 chk("R11");
    @(negedge clk); por_n = 1; cyc("R11");
    // random mix
    pulse = 0;
    for (int i = 0; i < 6000; i++) begin
      reg_wr      = ($urandom % 8) == 0;
      reg_wdata   = 2'($urandom);
      insn_done   = ($urandom % 2) == 0;
      irq_pend    = ($urandom % 16) == 0;
      ext_int_pin = NE'($urandom);
      ext_int_en  = NE'($urandom);
      ext_int_lvl = NE'($urandom);
      glob_int_en = ($urandom % 4) == 0;
      wdt_rst     = ($urandom % 64) == 0;
      if (pulse == 0 && ($urandom % 200) == 0) pulse = 1 + ($urandom % 40);
      ext_rst_pin = pulse > 0;
      if (pulse > 0) pulse--;
      cyc(st_tag());
    end
    finish_run();
  end
endmodule